// File: doc/BRIEF.md
# Shared Watchdog and Wakeup Timer

This block holds one slow counter that the host can use in either of two ways, but only in one way at a time. In watchdog mode the host has to restart the count again and again. If it misses the deadline, the block drops its ready output and sends a one-cycle reset pulse. That reset also clears the timer's own configuration. In wakeup mode the host asks the device to power down. The block then switches the regulators off, enters a hibernate state and blocks register access. When the programmed time has passed, it brings the regulators back up.

The counter moves forward only on a slow tick input, which is a one-clock-wide strobe at 2 kHz. A prescaler groups `TICKS_PER_UNIT` ticks (8000 by default, which is 4 s) into one unit. The host writes a 24-bit trigger value N, and the target is N−1 units. Values 0 and 1 are not legal targets. A single configuration write loads the trigger value, the mode and the enable together.

Top module: `wt_shared_timer`

## Requirements
- R1: After reset, ready and regulator enable are 1, the hibernate flag and the reset pulse are 0, and the timer is disabled.
- R2: While the timer is disabled, no number of ticks causes a reset pulse or any other output change.
- R3: In watchdog mode (mode bit 0) with enable 1 and trigger N ≥ 2, the reset pulse appears in the clock cycle right after the (N−1)×TICKS_PER_UNIT-th tick that follows the last restart.
- R4: The reset pulse lasts exactly one clock cycle, and ready is 0 during that cycle and 1 again afterwards.
- R5: A watchdog expiry returns the configuration to its reset state (disabled), so further ticks cause no reset until the host enables the timer again.
- R6: A kick outside hibernate restarts the count from zero. A kick and a tick in the same cycle count as a kick only.
- R7: With enable 1 and a trigger value of 0 or 1, the timer stays idle: ticks cause no reset, and a power-down request is ignored.
- R8: A power-down request is accepted only when the timer is enabled in wakeup mode (mode bit 1) with a legal trigger. In watchdog mode or while disabled it has no effect.
- R9: An accepted power-down request sets the hibernate flag and clears the regulator enable and ready outputs from the next clock cycle onward.
- R10: During hibernate, configuration writes and kicks are ignored. After (N−1)×TICKS_PER_UNIT ticks the hibernate flag clears and the regulator enable and ready outputs return to 1, with no reset pulse.
- R11: In wakeup mode outside hibernate the counter does not run, so ticks cause neither a reset nor a wakeup.
- R12: A configuration write outside hibernate restarts the count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 2 kHz time strobe, one clock wide |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_trig_i | input | 24 | Trigger value N (target = N−1 units) |
| cfg_mode_i | input | 1 | 0 = watchdog, 1 = wakeup |
| cfg_en_i | input | 1 | Timer enable |
| kick_i | input | 1 | Watchdog restart strobe |
| pdn_req_i | input | 1 | Power-down request |
| wdt_rst_o | output | 1 | Watchdog reset pulse |
| ready_o | output | 1 | Device ready |
| reg_en_o | output | 1 | Regulator enable |
| hib_o | output | 1 | Hibernate flag |

## Verification
The assertions assume that the tick, kick, write and power-down strobes are each one cycle wide and change only between clock edges. They also assume that a wakeup comes only from a tick. The stimulus drives every strobe for exactly one cycle, starting on a falling edge. Trigger values stay small so that expiry is reached within the run. Random kick intervals are drawn strictly below the target, and the trigger values are drawn from the legal range, so each random round ends in a known expiry tick.

// File: rtl/wt_pkg.sv
package wt_pkg;
    typedef enum logic {
        WT_MODE_WDOG = 1'b0,
        WT_MODE_WAKE = 1'b1
    } wt_mode_e;
endpackage

// File: rtl/wt_cfg_regs.sv
module wt_cfg_regs
    import wt_pkg::*;
#(
    parameter int TRIG_W = 24
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              we_i,
    input  logic [TRIG_W-1:0] trig_i,
    input  wt_mode_e          mode_i,
    input  logic              en_i,
    input  logic              wipe_i,
    output logic [TRIG_W-1:0] trig_o,
    output wt_mode_e          mode_o,
    output logic              armed_o
);
    localparam logic [TRIG_W-1:0] MIN_TRIG = TRIG_W'(2);

    typedef struct packed {
        logic [TRIG_W-1:0] trig;
        wt_mode_e          mode;
        logic              en;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wipe_i) begin
            cfg_d = '{trig: '0, mode: WT_MODE_WDOG, en: 1'b0};
        end else if (we_i) begin
            cfg_d = '{trig: trig_i, mode: mode_i, en: en_i};
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cfg_q <= '{trig: '0, mode: WT_MODE_WDOG, en: 1'b0};
        else         cfg_q <= cfg_d;
    end

    assign trig_o  = cfg_q.trig;
    assign mode_o  = cfg_q.mode;
    assign armed_o = cfg_q.en && (cfg_q.trig >= MIN_TRIG);
endmodule

// File: rtl/wt_unit_counter.sv
module wt_unit_counter #(
    parameter int TICKS_PER_UNIT = 8000,
    parameter int TRIG_W         = 24
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              clr_i,
    input  logic              run_i,
    input  logic [TRIG_W-1:0] trig_i,
    output logic              expire_o
);
    localparam int PRE_W = (TICKS_PER_UNIT > 1) ? $clog2(TICKS_PER_UNIT) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICKS_PER_UNIT - 1);

    typedef struct packed {
        logic [PRE_W-1:0]  pre;
        logic [TRIG_W-1:0] units;
    } cnt_t;

    cnt_t cnt_d, cnt_q;
    logic [TRIG_W-1:0] units_inc;
    logic [TRIG_W-1:0] target;
    logic              unit_done;

    assign units_inc = cnt_q.units + TRIG_W'(1);
    assign target    = trig_i - TRIG_W'(1);
    assign unit_done = run_i && (cnt_q.pre == PRE_LAST);

    always_comb begin
        expire_o = unit_done && (units_inc == target);
    end

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i || expire_o) begin
            cnt_d = '0;
        end else if (unit_done) begin
            cnt_d.pre   = '0;
            cnt_d.units = units_inc;
        end else if (run_i) begin
            cnt_d.pre = cnt_q.pre + PRE_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end
endmodule

// File: rtl/wt_shared_timer.sv
module wt_shared_timer
    import wt_pkg::*;
#(
    parameter int TICKS_PER_UNIT = 8000,
    parameter int TRIG_W         = 24
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              cfg_we_i,
    input  logic [TRIG_W-1:0] cfg_trig_i,
    input  logic              cfg_mode_i,
    input  logic              cfg_en_i,
    input  logic              kick_i,
    input  logic              pdn_req_i,
    output logic              wdt_rst_o,
    output logic              ready_o,
    output logic              reg_en_o,
    output logic              hib_o
);
    typedef struct packed {
        logic hib;
        logic rst;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [TRIG_W-1:0] trig;
    wt_mode_e          mode;
    logic              armed;
    logic              we_eff, kick_eff, pdn_ok, clr, run, expire;
    logic              wd_fire, wake;

    assign we_eff   = cfg_we_i && !ctl_q.hib;
    assign kick_eff = kick_i && !ctl_q.hib;
    assign pdn_ok   = pdn_req_i && !ctl_q.hib && !we_eff && armed
                      && (mode == WT_MODE_WAKE);
    assign clr      = we_eff || kick_eff || pdn_ok;
    assign run      = tick_i && armed && !clr
                      && ((mode == WT_MODE_WDOG) || ctl_q.hib);
    assign wd_fire  = expire && (mode == WT_MODE_WDOG);
    assign wake     = expire && (mode == WT_MODE_WAKE);

    wt_cfg_regs #(.TRIG_W(TRIG_W)) cfg_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (we_eff),
        .trig_i  (cfg_trig_i),
        .mode_i  (wt_mode_e'(cfg_mode_i)),
        .en_i    (cfg_en_i),
        .wipe_i  (wd_fire),
        .trig_o  (trig),
        .mode_o  (mode),
        .armed_o (armed)
    );

    wt_unit_counter #(.TICKS_PER_UNIT(TICKS_PER_UNIT), .TRIG_W(TRIG_W)) cnt_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .clr_i    (clr),
        .run_i    (run),
        .trig_i   (trig),
        .expire_o (expire)
    );

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.rst = wd_fire;
        if (ctl_q.hib) ctl_d.hib = !wake;
        else           ctl_d.hib = pdn_ok;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ctl_q <= '0;
        else         ctl_q <= ctl_d;
    end

    assign wdt_rst_o = ctl_q.rst;
    assign hib_o     = ctl_q.hib;
    assign reg_en_o  = !ctl_q.hib;
    assign ready_o   = !ctl_q.hib && !ctl_q.rst;
endmodule

// File: rtl/wt_chk.sv
module wt_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic tick_i,
    input logic kick_i,
    input logic pdn_req_i,
    input logic wdt_rst_o,
    input logic ready_o,
    input logic reg_en_o,
    input logic hib_o
);
    // R4
    rst_drops_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wdt_rst_o |-> !ready_o);
    // R4
    rst_single_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wdt_rst_o |=> !wdt_rst_o);
    // R3
    rst_after_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(wdt_rst_o) |-> ($past(tick_i) && !$past(kick_i)));
    // R9
    hib_regs_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hib_o |-> (!reg_en_o && !ready_o));
    // R8
    hib_needs_request_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(hib_o) |-> $past(pdn_req_i));
    // R10
    wake_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(hib_o) |-> ($past(tick_i) && !wdt_rst_o));
    // R10
    no_rst_in_hib_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hib_o |-> !wdt_rst_o);
endmodule

bind wt_shared_timer wt_chk chk_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .kick_i    (kick_i),
    .pdn_req_i (pdn_req_i),
    .wdt_rst_o (wdt_rst_o),
    .ready_o   (ready_o),
    .reg_en_o  (reg_en_o),
    .hib_o     (hib_o)
);

// File: tb/wt_shared_timer_tb.sv
module wt_shared_timer_tb_top;
    localparam int TPU    = 4;
    localparam int TRIG_W = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0, we = 1'b0, mode = 1'b0, en = 1'b0, kick = 1'b0, pdn = 1'b0;
    logic [TRIG_W-1:0] trig = '0;
    logic wdt_rst, ready, reg_en, hib;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    wt_shared_timer #(.TICKS_PER_UNIT(TPU), .TRIG_W(TRIG_W)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .cfg_we_i(we),
        .cfg_trig_i(trig), .cfg_mode_i(mode), .cfg_en_i(en),
        .kick_i(kick), .pdn_req_i(pdn),
        .wdt_rst_o(wdt_rst), .ready_o(ready), .reg_en_o(reg_en), .hib_o(hib)
    );

    function automatic int exp_ticks(int n);
        return (n - 1) * TPU;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(int t, bit m, bit e);
        trig = TRIG_W'(t); mode = m; en = e; we = 1'b1;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic do_kick();
        kick = 1'b1; @(negedge clk); kick = 1'b0;
    endtask

    task automatic do_pdn();
        pdn = 1'b1; @(negedge clk); pdn = 1'b0;
    endtask

    // ticks n times; returns number of reset pulses and index of the first
    task automatic ticks(int n, output int nrst, output int first);
        nrst = 0; first = -1;
        for (int i = 1; i <= n; i++) begin
            tick = 1'b1; @(negedge clk); tick = 1'b0;
            if (wdt_rst) begin
                nrst++;
                if (first < 0) first = i;
                @(negedge clk);
            end
        end
    endtask

    // ticks until hib clears; returns tick index
    task automatic ticks_to_wake(int lim, output int at);
        at = -1;
        for (int i = 1; i <= lim; i++) begin
            tick = 1'b1; @(negedge clk); tick = 1'b0;
            if (!hib && at < 0) at = i;
            if (at >= 0) break;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int nr, fi, at, n, r, rounds;
        void'($urandom(32'h2468));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk("R1 ready", ready, 1); chk("R1 reg_en", reg_en, 1);
        chk("R1 hib", hib, 0);     chk("R1 rst", wdt_rst, 0);
        // R2
        ticks(40, nr, fi); chk("R2 disabled resets", nr, 0);
        // R3/R4: watchdog N=3
        wr(3, 1'b0, 1'b1);
        ticks(exp_ticks(3) - 1, nr, fi); chk("R3 early", nr, 0);
        tick = 1'b1; @(negedge clk); tick = 1'b0;
        chk("R3 expiry pulse", wdt_rst, 1); chk("R4 ready low", ready, 0);
        @(negedge clk);
        chk("R4 pulse ends", wdt_rst, 0); chk("R4 ready back", ready, 1);
        // R5
        ticks(40, nr, fi); chk("R5 wiped", nr, 0);
        // R6: kick restarts, kick with tick counts as kick
        wr(2, 1'b0, 1'b1);
        ticks(3, nr, fi); do_kick();
        ticks(3, nr, fi); chk("R6 no reset after kick", nr, 0);
        tick = 1'b1; kick = 1'b1; @(negedge clk); tick = 1'b0; kick = 1'b0;
        chk("R6 kick wins over tick", wdt_rst, 0);
        ticks(exp_ticks(2), nr, fi); chk("R6 restart count", fi, exp_ticks(2));
        // R7: illegal triggers
        wr(1, 1'b0, 1'b1); ticks(20, nr, fi); chk("R7 trig1 idle", nr, 0);
        wr(0, 1'b1, 1'b1); do_pdn(); chk("R7 pdn ignored", hib, 0);
        chk("R7 regs on", reg_en, 1);
        // R8: pdn in watchdog mode / disabled
        wr(5, 1'b0, 1'b1); do_pdn(); chk("R8 pdn in wdog", hib, 0);
        wr(5, 1'b1, 1'b0); do_pdn(); chk("R8 pdn disabled", hib, 0);
        // R11: wake mode without hibernate
        wr(2, 1'b1, 1'b1);
        ticks(30, nr, fi); chk("R11 no reset", nr, 0); chk("R11 no hib", hib, 0);
        // R9/R10: hibernate N=4
        wr(4, 1'b1, 1'b1);
        do_pdn();
        chk("R9 hib", hib, 1); chk("R9 reg_en", reg_en, 0); chk("R9 ready", ready, 0);
        ticks(2, nr, fi);
        wr(2, 1'b0, 1'b1); do_kick();
        ticks_to_wake(100, at); chk("R10 wake tick", at + 2, exp_ticks(4));
        chk("R10 reg_en", reg_en, 1); chk("R10 ready", ready, 1); chk("R10 no rst", wdt_rst, 0);
        // R12: config write restarts
        wr(3, 1'b0, 1'b1);
        ticks(5, nr, fi); wr(3, 1'b0, 1'b1);
        ticks(exp_ticks(3), nr, fi); chk("R12 restart", fi, exp_ticks(3));
        // random rounds: R3, R6
        for (int it = 0; it < 20; it++) begin
            n = 2 + $urandom_range(0, 4);
            wr(n, 1'b0, 1'b1);
            rounds = $urandom_range(1, 3);
            for (int k = 0; k < rounds; k++) begin
                r = $urandom_range(0, exp_ticks(n) - 1);
                ticks(r, nr, fi); chk("R6 random kick window", nr, 0);
                do_kick();
            end
            ticks(exp_ticks(n) + 3, nr, fi);
            chk("R3 random expiry tick", fi, exp_ticks(n));
            chk("R5 random single reset", nr, 1);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule